// File: doc/BRIEF.md
# Eight-Lamp Automatic Pattern Sequencer

This block animates a row of eight lamps through a library of display patterns with no operator input. A step tick comes from a counter on the system clock, and each tick shows the next frame of the current pattern. The tick runs at one of two beat rates: slow, every half second, or fast, every quarter second. Each beat rate has its own set of eight patterns. A pattern plays for one or two full cycles. The pattern changes only when a cycle ends.

In regular mode the patterns follow a fixed order, and the beat flips after all eight patterns of one rate have played. In random mode a free-running 16-bit LFSR picks both the next pattern and its beat each time the pattern changes. An asynchronous active-high clear blanks the lamps at once and returns the block to its starting point. The parameter `CLK_HZ` sets the tick periods, so a bench can use a small value.

Top module: `lamp_pattern_seq`

## Requirements
- R1: While `clr_i` is high, `lamps_o` is 8'h00 at once, without waiting for a clock edge. The state returns to pattern 0 at the slow beat, frame 0, with the random source reloaded.
- R2: After `clr_i` falls, the first frame appears on the clock edge numbered `CLK_HZ/2 + 2`, counting from the first edge after the release. The lamps stay dark before that edge.
- R3: One slow step lasts `CLK_HZ/2` clock cycles and one fast step lasts `CLK_HZ/4` clock cycles. `lamps_o` changes only on a step tick.
- R4: The slow set is indexed 0 to 7. The frames are listed for eight lamps, with bit 7 at the left.
  - 0: one lamp goes from bit 7 to bit 0 and back, 14 frames (80,40,..,01,02,..,40).
  - 1: one lamp moves from bit 7 to bit 0, 8 frames.
  - 2: a bar fills from the left, 8 frames (80,C0,..,FF).
  - 3: two lamps meet in the centre and part again, 6 frames (81,42,24,18,24,42).
  - 4: one lamp jumps two places at a time, 4 frames (80,20,08,02).
  - 5: alternate lamps, 2 frames (AA,55).
  - 6: one lamp moves from bit 0 to bit 7, 8 frames.
  - 7: a bar fills from the left and then drains to the right, 16 frames, ending at 00.
- R5: In the fast set, each frame is the bitwise complement of the slow frame with the same index.
- R6: Successive patterns play 1, 2, 1, 2, ... full cycles. The count starts at 1 after a clear.
- R7: In regular mode the pattern index goes up by one at each change. When index 7 finishes, the index wraps to 0 and the beat flips.
- R8: A pattern change happens only at the end of a cycle. The first frame of the new pattern appears one step interval of the new beat after the last frame of the old pattern.
- R9: `rnd_mode_i` (1 = random) is read only at a pattern change. Toggling it inside a pattern leaves the frames unchanged.
- R10: The random source is a 16-bit LFSR.
  - It loads 16'hACE1 on clear and shifts left by one on every clock from the third edge after the release.
  - The new bit 0 is bit 15 ^ bit 13 ^ bit 12 ^ bit 10.
  - At a change in random mode, the new index is bits [2:0] of the value held before that edge, and the new beat is bit 3 (1 = fast).
  - The LFSR value is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| clr_i | input | 1 | Asynchronous clear, active high |
| rnd_mode_i | input | 1 | 0 = regular order, 1 = random pattern and beat |
| lamps_o | output | 8 | Lamp vector, bit 7 at the left |

## Verification
Every frame lands exactly one step interval after the previous one. The first frame after a clear lands `CLK_HZ/2 + 2` edges after the release, because two edges go to the reset synchroniser. The bench therefore waits an exact count of edges and samples 1 ns after the edge that should load the frame. It also samples one edge earlier to confirm the old frame is still held. The clear is checked 1 ns after it rises, with no edge in between. For the random change, the bench counts the LFSR shifts from the release (111 before the first change) and works out the expected index and beat.

// File: rtl/lamp_seq_pkg.sv
`timescale 1ns/1ps
package lamp_seq_pkg;
  localparam int unsigned NUM_SHAPES = 8;
  localparam int unsigned SHAPE_W    = $clog2(NUM_SHAPES);
  localparam int unsigned RNG_W      = 16;

  typedef enum logic {BEAT_SLOW = 1'b0, BEAT_FAST = 1'b1} beat_e;
  typedef logic [SHAPE_W-1:0] shape_t;
endpackage

// File: rtl/lamp_rst_sync.sv
`timescale 1ns/1ps
module lamp_rst_sync (
  input  logic clk_i,
  input  logic clr_i,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) sync_q <= '0;
    else       sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/lamp_beat_timer.sv
`timescale 1ns/1ps
module lamp_beat_timer
  import lamp_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  beat_e beat_i,
  output logic  tick_o
);
  localparam int unsigned SLOW_CNT = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;
  localparam int unsigned FAST_CNT = (CLK_HZ / 4 > 0) ? CLK_HZ / 4 : 1;
  localparam int unsigned CNT_W    = (SLOW_CNT > 1) ? $clog2(SLOW_CNT) : 1;
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CNT - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CNT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt;

  always_comb begin
    last_cnt = (beat_i == BEAT_FAST) ? FAST_LAST : SLOW_LAST;
    tick_o   = (cnt_q == last_cnt);
    cnt_d    = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i == BEAT_FAST) |-> (cnt_q <= FAST_LAST));
endmodule

// File: rtl/lamp_lfsr.sv
`timescale 1ns/1ps
module lamp_lfsr
  import lamp_seq_pkg::*;
#(
  parameter logic [RNG_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [SHAPE_W:0] pick_o
);
  logic [RNG_W-1:0] rng_q, rng_d;

  always_comb begin
    rng_d = {rng_q[RNG_W-2:0], rng_q[15] ^ rng_q[13] ^ rng_q[12] ^ rng_q[10]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rng_q <= SEED;
    else         rng_q <= rng_d;
  end

  assign pick_o = rng_q[SHAPE_W:0];

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_q != '0);
endmodule

// File: rtl/lamp_shape_rom.sv
`timescale 1ns/1ps
module lamp_shape_rom
  import lamp_seq_pkg::*;
#(
  parameter int unsigned LAMPS  = 8,
  parameter int unsigned STEP_W = $clog2(2 * LAMPS)
) (
  input  shape_t            shape_i,
  input  beat_e             beat_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [LAMPS-1:0]  frame_o,
  output logic [STEP_W-1:0] last_o
);
  localparam int HALF = LAMPS / 2;
  localparam int NL   = LAMPS;

  logic [LAMPS-1:0] alt_v, one_v, all_v, base;
  int k, p;

  for (genvar g = 0; g < LAMPS; g++) begin : g_alt
    assign alt_v[g] = (g % 2) == 1;
  end

  always_comb begin
    one_v  = LAMPS'(1);
    all_v  = '1;
    k      = int'(step_i);
    p      = 0;
    base   = '0;
    last_o = '0;
    case (shape_i)
      3'd0: begin
        p      = (k < NL) ? k : 2 * NL - 2 - k;
        base   = one_v << (NL - 1 - p);
        last_o = STEP_W'(2 * NL - 3);
      end
      3'd1: begin
        base   = one_v << (NL - 1 - k);
        last_o = STEP_W'(NL - 1);
      end
      3'd2: begin
        base   = ~(all_v >> (k + 1));
        last_o = STEP_W'(NL - 1);
      end
      3'd3: begin
        p      = (k < HALF) ? k : 2 * HALF - 2 - k;
        base   = (one_v << (NL - 1 - p)) | (one_v << p);
        last_o = STEP_W'(2 * HALF - 3);
      end
      3'd4: begin
        base   = one_v << (NL - 1 - 2 * k);
        last_o = STEP_W'(HALF - 1);
      end
      3'd5: begin
        base   = step_i[0] ? ~alt_v : alt_v;
        last_o = STEP_W'(1);
      end
      3'd6: begin
        base   = one_v << k;
        last_o = STEP_W'(NL - 1);
      end
      default: begin
        base   = (k < NL) ? ~(all_v >> (k + 1)) : (all_v >> (k - NL + 1));
        last_o = STEP_W'(2 * NL - 1);
      end
    endcase
    frame_o = (beat_i == BEAT_FAST) ? ~base : base;
  end
endmodule

// File: rtl/lamp_sequencer.sv
`timescale 1ns/1ps
module lamp_sequencer
  import lamp_seq_pkg::*;
#(
  parameter int unsigned LAMPS  = 8,
  parameter int unsigned STEP_W = $clog2(2 * LAMPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rnd_mode_i,
  input  logic [SHAPE_W:0] pick_i,
  output beat_e            beat_o,
  output logic [LAMPS-1:0] lamps_o
);
  shape_t            shape_q, shape_d;
  beat_e             beat_q, beat_d;
  logic [STEP_W-1:0] step_q, step_d, step_last;
  logic              rep_q, rep_d, twice_q, twice_d;
  logic [LAMPS-1:0]  lamps_q, lamps_d, frame;
  logic              at_last, finish, swap;

  lamp_shape_rom #(.LAMPS(LAMPS), .STEP_W(STEP_W)) u_rom (
    .shape_i (shape_q),
    .beat_i  (beat_q),
    .step_i  (step_q),
    .frame_o (frame),
    .last_o  (step_last)
  );

  always_comb begin
    at_last = (step_q == step_last);
    finish  = at_last && (!twice_q || rep_q);
    swap    = tick_i && finish;
    shape_d = shape_q;
    beat_d  = beat_q;
    step_d  = step_q;
    rep_d   = rep_q;
    twice_d = twice_q;
    lamps_d = lamps_q;
    if (tick_i) begin
      lamps_d = frame;
      if (at_last) begin
        step_d = '0;
        if (finish) begin
          rep_d   = 1'b0;
          twice_d = ~twice_q;
          if (rnd_mode_i) begin
            shape_d = pick_i[SHAPE_W-1:0];
            beat_d  = beat_e'(pick_i[SHAPE_W]);
          end else begin
            shape_d = shape_q + 1'b1;
            if (shape_q == SHAPE_W'(NUM_SHAPES - 1))
              beat_d = (beat_q == BEAT_SLOW) ? BEAT_FAST : BEAT_SLOW;
          end
        end else begin
          rep_d = 1'b1;
        end
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shape_q <= '0;
      beat_q  <= BEAT_SLOW;
      step_q  <= '0;
      rep_q   <= 1'b0;
      twice_q <= 1'b0;
      lamps_q <= '0;
    end else begin
      shape_q <= shape_d;
      beat_q  <= beat_d;
      step_q  <= step_d;
      rep_q   <= rep_d;
      twice_q <= twice_d;
      lamps_q <= lamps_d;
    end
  end

  assign beat_o  = beat_q;
  assign lamps_o = lamps_q;

  // R4
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= step_last);

  // R8
  shape_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(shape_q) && $stable(beat_q)));

  // R7
  shape_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap && !rnd_mode_i) |=> ((shape_q - $past(shape_q)) == SHAPE_W'(1)));

  // R7
  beat_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap && !rnd_mode_i && shape_q == SHAPE_W'(NUM_SHAPES - 1)) |=> (beat_q != $past(beat_q)));

  // R6
  repeat_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |=> (twice_q != $past(twice_q)));
endmodule

// File: rtl/lamp_pattern_seq.sv
`timescale 1ns/1ps
module lamp_pattern_seq
  import lamp_seq_pkg::*;
#(
  parameter int unsigned      CLK_HZ   = 50_000_000,
  parameter int unsigned      LAMPS    = 8,
  parameter logic [RNG_W-1:0] RNG_SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             rnd_mode_i,
  output logic [LAMPS-1:0] lamps_o
);
  localparam int unsigned STEP_W = $clog2(2 * LAMPS);

  logic             rst_n, tick;
  beat_e            beat;
  logic [SHAPE_W:0] pick;

  lamp_rst_sync u_rst (
    .clk_i  (clk_i),
    .clr_i  (clr_i),
    .rst_no (rst_n)
  );

  lamp_beat_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .beat_i (beat),
    .tick_o (tick)
  );

  lamp_lfsr #(.SEED(RNG_SEED)) u_rng (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pick_o (pick)
  );

  lamp_sequencer #(.LAMPS(LAMPS), .STEP_W(STEP_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .rnd_mode_i (rnd_mode_i),
    .pick_i     (pick),
    .beat_o     (beat),
    .lamps_o    (lamps_o)
  );

  // R3
  lamps_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tick |=> $stable(lamps_o));
endmodule

// File: tb/test_lamp_pattern_seq.sv
`timescale 1ns/1ps
module test_lamp_pattern_seq;
  localparam int unsigned CLK_HZ = 16;
  localparam int unsigned SLOW   = CLK_HZ / 2;
  localparam int unsigned FAST   = CLK_HZ / 4;
  localparam int NREG = 38;

  // frames 0..37 in regular mode: shape 0 once, shape 1 twice, shape 2 once
  localparam logic [7:0] REG_FRAMES [NREG] = '{
    8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40,
    8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01,
    8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01,
    8'h80, 8'hC0, 8'hE0, 8'hF0, 8'hF8, 8'hFC, 8'hFE, 8'hFF};
  localparam logic [7:0] FIRST_FRAME [8] = '{8'h80, 8'h80, 8'h80, 8'h81, 8'h80, 8'hAA, 8'h01, 8'h80};

  logic       clk = 1'b0;
  logic       clr, rnd;
  logic [7:0] lamps;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  lamp_pattern_seq #(.CLK_HZ(CLK_HZ), .LAMPS(8), .RNG_SEED(16'hACE1)) i_lamp_pattern_seq (
    .clk_i      (clk),
    .clr_i      (clr),
    .rnd_mode_i (rnd),
    .lamps_o    (lamps)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lamps=%h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] rng_after(input int n);
    logic [15:0] s = 16'hACE1;
    for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    return s;
  endfunction

  initial begin
    logic [15:0] s;
    logic [7:0]  exp;
    int          lim;
    clr = 1'b1;
    rnd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset dark", lamps, 8'h00);
    clr = 1'b0;
    edges(SLOW + 1);
    chk("R2 dark before first frame", lamps, 8'h00);
    edges(1);
    chk("R2 first frame", lamps, REG_FRAMES[0]);
    for (int i = 1; i < NREG; i++) begin
      if (i == 2)  rnd = 1'b1;  // R9 toggle inside pattern 0
      if (i == 10) rnd = 1'b0;
      edges(SLOW - 1);
      chk("R3 frame held between ticks", lamps, REG_FRAMES[i-1]);
      edges(1);
      chk("R4 R6 R7 R9 regular table", lamps, REG_FRAMES[i]);
    end
    for (int i = NREG; i < 98; i++) begin
      edges(SLOW);
      if (i == 38) chk("R4 pair meet", lamps, 8'h81);
      if (i == 41) chk("R4 pair centre", lamps, 8'h18);
      if (i == 50) chk("R6 jump start", lamps, 8'h80);
      if (i == 51) chk("R4 jump by two", lamps, 8'h20);
      if (i == 54) chk("R4 alternate", lamps, 8'hAA);
      if (i == 58) chk("R4 leftward", lamps, 8'h01);
      if (i == 66) chk("R4 fill and drain", lamps, 8'h80);
      if (i == 97) chk("R4 drained end", lamps, 8'h00);
    end
    edges(FAST - 1);
    chk("R8 old frame held", lamps, 8'h00);
    edges(1);
    chk("R5 R7 fast set after index 7", lamps, 8'h7F);
    edges(FAST);
    chk("R3 fast interval", lamps, 8'hBF);

    @(posedge clk);
    #2 clr = 1'b1;
    #1 chk("R1 async clear", lamps, 8'h00);
    repeat (3) @(negedge clk);
    rnd = 1'b1;
    clr = 1'b0;
    edges(SLOW + 2);
    chk("R1 R2 restart pattern 0", lamps, 8'h80);
    for (int i = 1; i < 14; i++) begin
      edges(SLOW);
      chk("R9 random mode first pattern", lamps, REG_FRAMES[i]);
    end
    s   = rng_after(111);
    exp = s[3] ? ~FIRST_FRAME[s[2:0]] : FIRST_FRAME[s[2:0]];
    lim = s[3] ? FAST : SLOW;
    edges(lim - 1);
    chk("R8 boundary wait", lamps, 8'h40);
    edges(1);
    chk("R10 random pick", lamps, exp);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2: run not finished, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule